// File: doc/BRIEF.md
# FIFO-Side DMA Request Generator

This block drives the request side of a single-word DMA handshake between a display controller's data FIFOs and an external microcontroller's DMA engine. Software programs a transfer mode, a serviced-FIFO direction, a trigger limit, a burst word count and a total word count, then pulses `start`. The block watches the fill level of the chosen FIFO and raises `dmaReq`. Each word moves on one `dmaReq`/`dmaAck` handshake, and the matching push or pop strobe goes to the FIFO in that same cycle.

Three transfer modes are provided.
- In demand mode, one trigger opens a session. Requests then continue word by word until the output FIFO is empty or the input FIFO is full.
- In step mode, the trigger condition is checked again before every word.
- In burst mode, a run of words is committed once, and the FIFO level is not checked again until that run ends.

A busy flag stays high for the whole transfer. A one-cycle done pulse marks the acknowledge of the last word.

Top module: `fifoDmaReq`

## Requirements
- R1: The mode field `cfgMode` is decoded as follows: 2'b00 is step, 2'b01 is burst and 2'b10 is demand. The value 2'b11 is reserved. A `start` with the reserved mode, or with `cfgCount` equal to 0, is ignored and `busy` stays low.
- R2: `cfgDirIn`=1 services the input FIFO, and each accepted word pulses `pushStrobe`. `cfgDirIn`=0 services the output FIFO, and each accepted word pulses `popStrobe`. The two strobes are never high together.
- R3: For the output FIFO, the trigger condition is `outLevel` >= limit. A `cfgLimit` of 0 acts as a limit of 1.
- R4: For the input FIFO, the trigger condition is (DEPTH - `inLevel`) >= limit. Outside burst mode, no word is pushed while `inLevel` equals DEPTH.
- R5: In demand mode, once the trigger condition has been met, requests continue until the output FIFO is empty or the input FIFO is full. After that, the trigger condition must be met again. No pop is issued while `outLevel` is 0.
- R6: In step mode, the trigger condition is checked again before every word.
- R7: In burst mode, a met trigger commits min(`cfgBlock`, remaining words) words. A `cfgBlock` of 0 counts as 1. The request is held for all of those words without looking at the FIFO level.
- R8: `dmaReq` is registered and rises one cycle after its condition is seen. One word is accepted in each cycle where `dmaReq` and `dmaAck` are both high. `dmaReq` is low in the cycle after every accepted word.
- R9: `busy` rises the cycle after an accepted `start`. It falls in the cycle after the last of `cfgCount` words is accepted, and `done` is high for exactly that one cycle. `dmaReq` is low whenever `busy` is low.
- R10: After reset, `dmaReq`, `pushStrobe`, `popStrobe`, `busy` and `done` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle pulse that begins a transfer using the current configuration |
| cfgMode | input | 2 | Transfer mode: 00 step, 01 burst, 10 demand, 11 reserved |
| cfgDirIn | input | 1 | 1 selects the input FIFO, 0 selects the output FIFO |
| cfgLimit | input | LW | Trigger limit in words (0 acts as 1) |
| cfgBlock | input | BW | Words per burst (0 acts as 1) |
| cfgCount | input | CW | Total words to transfer |
| inLevel | input | LW | Fill level of the input FIFO |
| outLevel | input | LW | Fill level of the output FIFO |
| dmaReq | output | 1 | Request toward the DMA engine |
| dmaAck | input | 1 | Acknowledge from the DMA engine |
| pushStrobe | output | 1 | One word is written into the input FIFO |
| popStrobe | output | 1 | One word is read from the output FIFO |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle pulse when the transfer completes |

## Verification
The bench targets the following corner cases:
- A level one below the limit. A block that compared with the wrong inequality would raise a request here.
- A zero limit. A block that did not treat 0 as 1 would request from an empty FIFO.
- A demand session that drains to empty and then sees a single new word below the limit. A block that kept the session open would pop again.
- A burst that outlasts the FIFO contents and must keep requesting, and a final burst shorter than the block size. A block that checked the level in the middle of a burst would stall, and one that ignored the remaining count would overrun `cfgCount`.
- The input direction against a nearly full FIFO, and a reserved-mode start.

Because acknowledges arrive with random delays, a missing recovery cycle or a miscounted word shows up as a mismatch in request timing or a difference in the word total.

// File: rtl/fdr_pkg.sv
package fdr_pkg;

  typedef enum logic [1:0] {
    MODE_STEP   = 2'b00,
    MODE_BURST  = 2'b01,
    MODE_DEMAND = 2'b10,
    MODE_RSVD   = 2'b11
  } xferMode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadCfg;
    logic decCount;
    logic loadBurst;
    logic decBurst;
    logic clrBurst;
  } dpStrobes_t;

endpackage

// File: rtl/fdrDatapath.sv
module fdrDatapath
  import fdr_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CW    = 16,
  parameter int BW    = 4,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobes_t       strb,
  input  logic [1:0]       cfgMode,
  input  logic             cfgDirIn,
  input  logic [LW-1:0]    cfgLimit,
  input  logic [BW-1:0]    cfgBlock,
  input  logic [CW-1:0]    cfgCount,
  input  logic [LW-1:0]    inLevel,
  input  logic [LW-1:0]    outLevel,
  output xferMode_e        curMode,
  output logic             curDirIn,
  output logic             countIsOne,
  output logic             burstActive,
  output logic             trigger,
  output logic             notDrained,
  output logic             startOk
);

  localparam logic [LW:0]   DEPTH_W = (LW+1)'(DEPTH);
  localparam logic [LW-1:0] FULL_L  = LW'(DEPTH);

  xferMode_e      modeQ;
  logic           dirQ;
  logic [LW-1:0]  limQ;
  logic [BW-1:0]  blkQ;
  logic [CW-1:0]  countQ;
  logic [CW-1:0]  burstQ;
  logic [LW:0]    freeSlots;
  logic [CW-1:0]  burstSeed;

  // Captured configuration, zero limit and zero block promoted to one
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= MODE_STEP;
      dirQ  <= 1'b0;
      limQ  <= LW'(1);
      blkQ  <= BW'(1);
    end else if (strb.loadCfg) begin
      modeQ <= xferMode_e'(cfgMode);
      dirQ  <= cfgDirIn;
      limQ  <= (cfgLimit == '0) ? LW'(1) : cfgLimit;
      blkQ  <= (cfgBlock == '0) ? BW'(1) : cfgBlock;
    end
  end

  // Remaining word counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              countQ <= '0;
    else if (strb.loadCfg)  countQ <= cfgCount;
    else if (strb.decCount) countQ <= countQ - CW'(1);
  end

  // Burst run length: the smaller of block size and what is left
  assign burstSeed = (CW'(blkQ) < countQ) ? CW'(blkQ) : countQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               burstQ <= '0;
    else if (strb.clrBurst)  burstQ <= '0;
    else if (strb.loadBurst) burstQ <= burstSeed;
    else if (strb.decBurst && burstQ != '0) burstQ <= burstQ - CW'(1);
  end

  // Level comparisons for the serviced FIFO
  assign freeSlots = DEPTH_W - {1'b0, inLevel};

  always_comb begin
    if (dirQ) begin
      trigger    = freeSlots >= {1'b0, limQ};
      notDrained = inLevel != FULL_L;
    end else begin
      trigger    = outLevel >= limQ;
      notDrained = outLevel != '0;
    end
  end

  assign startOk     = (cfgMode != MODE_RSVD) && (cfgCount != '0);
  assign curMode     = modeQ;
  assign curDirIn    = dirQ;
  assign countIsOne  = countQ == CW'(1);
  assign burstActive = burstQ != '0;

endmodule

// File: rtl/fdrControl.sv
module fdrControl
  import fdr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       startOk,
  input  logic       dmaAck,
  input  xferMode_e  curMode,
  input  logic       curDirIn,
  input  logic       countIsOne,
  input  logic       burstActive,
  input  logic       trigger,
  input  logic       notDrained,
  output dpStrobes_t strb,
  output logic       dmaReq,
  output logic       pushStrobe,
  output logic       popStrobe,
  output logic       busy,
  output logic       done
);

  logic reqQ, busyQ, doneQ, activeQ;
  logic reqD, busyD, doneD, activeD;
  logic accept;

  assign accept = reqQ && dmaAck;

  always_comb begin
    strb    = '0;
    reqD    = 1'b0;
    busyD   = busyQ;
    doneD   = 1'b0;
    activeD = activeQ;
    if (!busyQ) begin
      activeD       = 1'b0;
      strb.clrBurst = 1'b1;
      if (start && startOk) begin
        strb.loadCfg = 1'b1;
        busyD        = 1'b1;
      end
    end else if (accept) begin
      // request falls for one cycle after each accepted word
      strb.decCount = 1'b1;
      strb.decBurst = burstActive;
      if (countIsOne) begin
        busyD         = 1'b0;
        doneD         = 1'b1;
        activeD       = 1'b0;
        strb.clrBurst = 1'b1;
      end
    end else begin
      unique case (curMode)
        MODE_DEMAND: begin
          activeD = (activeQ || trigger) && notDrained;
          reqD    = activeD;
        end
        MODE_BURST: begin
          if (burstActive) begin
            reqD = 1'b1;
          end else if (trigger) begin
            strb.loadBurst = 1'b1;
            reqD           = 1'b1;
          end
        end
        default: reqD = trigger;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqQ    <= 1'b0;
      busyQ   <= 1'b0;
      doneQ   <= 1'b0;
      activeQ <= 1'b0;
    end else begin
      reqQ    <= reqD;
      busyQ   <= busyD;
      doneQ   <= doneD;
      activeQ <= activeD;
    end
  end

  assign dmaReq     = reqQ;
  assign busy       = busyQ;
  assign done       = doneQ;
  assign pushStrobe = accept && curDirIn;
  assign popStrobe  = accept && !curDirIn;

endmodule

// File: rtl/fifoDmaReq.sv
module fifoDmaReq
  import fdr_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CW    = 16,
  parameter int BW    = 4,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [1:0]    cfgMode,
  input  logic          cfgDirIn,
  input  logic [LW-1:0] cfgLimit,
  input  logic [BW-1:0] cfgBlock,
  input  logic [CW-1:0] cfgCount,
  input  logic [LW-1:0] inLevel,
  input  logic [LW-1:0] outLevel,
  output logic          dmaReq,
  input  logic          dmaAck,
  output logic          pushStrobe,
  output logic          popStrobe,
  output logic          busy,
  output logic          done
);

  dpStrobes_t strb;
  xferMode_e  curMode;
  logic       curDirIn, countIsOne, burstActive, trigger, notDrained, startOk;

  fdrDatapath #(.DEPTH(DEPTH), .CW(CW), .BW(BW)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .cfgMode(cfgMode), .cfgDirIn(cfgDirIn), .cfgLimit(cfgLimit),
    .cfgBlock(cfgBlock), .cfgCount(cfgCount),
    .inLevel(inLevel), .outLevel(outLevel),
    .curMode(curMode), .curDirIn(curDirIn), .countIsOne(countIsOne),
    .burstActive(burstActive), .trigger(trigger), .notDrained(notDrained),
    .startOk(startOk)
  );

  fdrControl u_ctl (
    .clk(clk), .rstN(rstN), .start(start), .startOk(startOk), .dmaAck(dmaAck),
    .curMode(curMode), .curDirIn(curDirIn), .countIsOne(countIsOne),
    .burstActive(burstActive), .trigger(trigger), .notDrained(notDrained),
    .strb(strb), .dmaReq(dmaReq), .pushStrobe(pushStrobe),
    .popStrobe(popStrobe), .busy(busy), .done(done)
  );

endmodule

// File: rtl/fdrChecker.sv
module fdrChecker #(
  parameter int DEPTH = 16,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rstN,
  input logic          start,
  input logic [1:0]    cfgMode,
  input logic [LW-1:0] inLevel,
  input logic [LW-1:0] outLevel,
  input logic          dmaReq,
  input logic          dmaAck,
  input logic          pushStrobe,
  input logic          popStrobe,
  input logic          busy,
  input logic          done
);

  AST_REQ_RECOVERY: assert property (@(posedge clk) disable iff (!rstN)
    (dmaReq && dmaAck) |=> !dmaReq); // R8

  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !dmaReq); // R9

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy))); // R9

  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({pushStrobe, popStrobe})); // R2

  AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    (popStrobe && cfgMode != 2'b01) |-> (outLevel != '0)); // R5

  AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (pushStrobe && cfgMode != 2'b01) |-> (inLevel != LW'(DEPTH))); // R4

  AST_RESERVED_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && cfgMode == 2'b11) |=> !busy); // R1

endmodule

bind fifoDmaReq fdrChecker #(.DEPTH(DEPTH)) u_fdrChecker (
  .clk(clk), .rstN(rstN), .start(start), .cfgMode(cfgMode),
  .inLevel(inLevel), .outLevel(outLevel), .dmaReq(dmaReq), .dmaAck(dmaAck),
  .pushStrobe(pushStrobe), .popStrobe(popStrobe), .busy(busy), .done(done)
);

// File: tb/test_fifoDmaReq.sv
module test_fifoDmaReq;
  localparam int DEPTH = 16;
  localparam int CW    = 16;
  localparam int BW    = 4;
  localparam int LW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [1:0]    cfgMode = 2'b10;
  logic          cfgDirIn = 1'b0;
  logic [LW-1:0] cfgLimit = '0;
  logic [BW-1:0] cfgBlock = '0;
  logic [CW-1:0] cfgCount = '0;
  logic [LW-1:0] inLevel = '0;
  logic [LW-1:0] outLevel = '0;
  logic          dmaAck = 1'b0;
  logic          dmaReq, pushStrobe, popStrobe, busy, done;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk; // 250 MHz

  fifoDmaReq #(.DEPTH(DEPTH), .CW(CW), .BW(BW)) i_fifoDmaReq (
    .clk(clk), .rstN(rstN), .start(start), .cfgMode(cfgMode),
    .cfgDirIn(cfgDirIn), .cfgLimit(cfgLimit), .cfgBlock(cfgBlock),
    .cfgCount(cfgCount), .inLevel(inLevel), .outLevel(outLevel),
    .dmaReq(dmaReq), .dmaAck(dmaAck), .pushStrobe(pushStrobe),
    .popStrobe(popStrobe), .busy(busy), .done(done)
  );

  // ---------------- behavioural reference ----------------
  int mReq, mBusy, mDone, mActive, mBurst, mCount, mMode, mDir, mLim, mBlk;
  int nReq, nBusy, nDone, nActive, nBurst, nCount;
  int trig, open;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mReq = 0; mBusy = 0; mDone = 0; mActive = 0; mBurst = 0; mCount = 0;
      mMode = 0; mDir = 0; mLim = 1; mBlk = 1;
    end else begin
      trig = mDir ? ((DEPTH - int'(inLevel)) >= mLim) : (int'(outLevel) >= mLim);
      open = mDir ? (int'(inLevel) != DEPTH) : (int'(outLevel) != 0);
      nReq = 0; nBusy = mBusy; nDone = 0; nActive = mActive;
      nBurst = mBurst; nCount = mCount;
      if (mBusy == 0) begin
        nActive = 0; nBurst = 0;
        if (start && cfgMode != 2'b11 && cfgCount != 0) begin
          nBusy = 1; nCount = int'(cfgCount); mMode = int'(cfgMode);
          mDir = int'(cfgDirIn);
          mLim = (cfgLimit == 0) ? 1 : int'(cfgLimit);
          mBlk = (cfgBlock == 0) ? 1 : int'(cfgBlock);
        end
      end else if (mReq != 0 && dmaAck) begin
        nCount = mCount - 1;
        if (mBurst > 0) nBurst = mBurst - 1;
        if (mCount == 1) begin nBusy = 0; nDone = 1; nActive = 0; nBurst = 0; end
      end else if (mMode == 2) begin
        nActive = ((mActive != 0) || (trig != 0)) && (open != 0);
        nReq = nActive;
      end else if (mMode == 1) begin
        if (mBurst > 0) nReq = 1;
        else if (trig != 0) begin
          nBurst = (mBlk < mCount) ? mBlk : mCount;
          nReq = 1;
        end
      end else begin
        nReq = trig;
      end
      mReq = nReq; mBusy = nBusy; mDone = nDone; mActive = nActive;
      mBurst = nBurst; mCount = nCount;
    end
  end

  // ---------------- checking helpers ----------------
  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  bit ackEn = 1'b1;
  bit pendPush, pendPop;
  int words, pops, reqSeen, doneSeen;

  // one clock: apply FIFO effect of last word, compare, drive acknowledge
  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pendPush) inLevel = inLevel + 1'b1;
      if (pendPop && outLevel != 0) outLevel = outLevel - 1'b1;
      check("R8 dmaReq timing", int'(dmaReq), mReq);
      check("R9 busy", int'(busy), mBusy);
      check("R9 done", int'(done), mDone);
      reqSeen  += int'(dmaReq);
      doneSeen += int'(done);
      dmaAck = ackEn && dmaReq && (($urandom % 4) != 0);
      #1;
      check("R2 pushStrobe", int'(pushStrobe), int'(mReq != 0 && dmaAck && mDir == 1));
      check("R2 popStrobe", int'(popStrobe), int'(mReq != 0 && dmaAck && mDir == 0));
      pendPush = pushStrobe;
      pendPop  = popStrobe;
      words += int'(pushStrobe || popStrobe);
      pops  += int'(popStrobe);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; start = 1'b0; dmaAck = 1'b0;
    pendPush = 1'b0; pendPop = 1'b0;
    repeat (2) @(negedge clk);
    check("R10 reset dmaReq", int'(dmaReq), 0);
    check("R10 reset busy", int'(busy), 0);
    check("R10 reset done", int'(done), 0);
    check("R10 reset strobes", int'(pushStrobe || popStrobe), 0);
    rstN = 1'b1;
    words = 0; pops = 0; reqSeen = 0; doneSeen = 0;
  endtask

  task automatic kick(input logic [1:0] m, input logic d, input int lim,
                      input int blk, input int cnt);
    cfgMode = m; cfgDirIn = d; cfgLimit = LW'(lim);
    cfgBlock = BW'(blk); cfgCount = CW'(cnt);
    start = 1'b1;
    step(1);
    start = 1'b0;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // ---------------- scenarios ----------------
  initial begin
    doReset();

    // R1 reserved mode start is ignored
    kick(2'b11, 1'b0, 1, 1, 5);
    step(4);
    check("R1 reserved mode keeps busy low", int'(busy), 0);
    check("R1 reserved mode no request", reqSeen, 0);

    // R3 / R5 demand on output FIFO, limit 3
    doReset();
    outLevel = 2;
    kick(2'b10, 1'b0, 3, 1, 20);
    check("R9 busy one cycle after start", int'(busy), 1);
    step(8);
    check("R3 no request below limit", reqSeen, 0);
    outLevel = 3;
    step(40);
    check("R5 demand drains to empty", int'(outLevel), 0);
    check("R5 demand word count", words, 3);
    outLevel = 1;
    step(20);
    check("R5 session closed below limit", words, 3);

    // R6 step mode rechecks per word
    doReset();
    outLevel = 3;
    kick(2'b00, 1'b0, 2, 1, 10);
    step(40);
    check("R6 step mode stops at limit", words, 2);
    check("R6 step mode leftover level", int'(outLevel), 1);

    // R3 zero limit acts as one, R9 done
    doReset();
    outLevel = 1;
    kick(2'b10, 1'b0, 0, 1, 2);
    step(20);
    check("R3 zero limit single word", words, 1);
    outLevel = outLevel + 1'b1;
    step(20);
    check("R3 zero limit second word", words, 2);
    check("R9 done pulse once", doneSeen, 1);
    check("R9 busy cleared", int'(busy), 0);

    // R9 count exhausts before FIFO empties
    doReset();
    outLevel = 8;
    kick(2'b10, 1'b0, 1, 1, 3);
    step(40);
    check("R9 count limits words", words, 3);
    check("R9 level left after count", int'(outLevel), 5);
    check("R9 single done", doneSeen, 1);

    // R7 burst outlasts FIFO, then a short final burst
    doReset();
    outLevel = 1;
    kick(2'b01, 1'b0, 1, 4, 6);
    step(60);
    check("R7 burst ignores level", words, 4);
    check("R7 burst busy after first run", int'(busy), 1);
    outLevel = 5;
    step(60);
    check("R7 short final burst", words, 6);
    check("R7 burst leftover level", int'(outLevel), 3);
    check("R9 burst done", doneSeen, 1);

    // R4 / R2 demand on input FIFO, limit 4
    doReset();
    inLevel = 14;
    kick(2'b10, 1'b1, 4, 1, 30);
    step(10);
    check("R4 no request with too little room", words, 0);
    inLevel = 12;
    step(40);
    check("R4 fills to full", int'(inLevel), DEPTH);
    check("R4 input word count", words, 4);
    inLevel = 15;
    step(20);
    check("R4 room below limit ignored", words, 4);
    inLevel = 10;
    step(60);
    check("R5 input session fills", int'(inLevel), DEPTH);
    check("R2 input direction never pops", pops, 0);

    // R8 starved acknowledge keeps request high
    doReset();
    outLevel = 4;
    ackEn = 1'b0;
    kick(2'b10, 1'b0, 1, 1, 4);
    step(6);
    check("R8 request held without ack", int'(dmaReq), 1);
    check("R8 no word without ack", words, 0);
    ackEn = 1'b1;
    step(40);
    check("R8 all words after ack", words, 4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule